// File: doc/BRIEF.md
# Word-Wide Serial EEPROM Device Model

This block is the device side of a 256-word by 16-bit serial EEPROM, written as synthesizable logic that runs on a system clock. A host drives four serial pins: an active-low select, a shift clock, a data input, and a separately enabled data output. It also drives an abort input, and it reads a ready output. The four inputs are resynchronised into the system clock domain, and the shift-clock edges are taken from the synchronised copy. The host clock must therefore stay well below the system clock rate.

A frame starts after select goes low. The block searches the incoming bits for a fixed start nibble, then takes a 4-bit command nibble and an 8-bit address, and for the two write commands it then takes a 16-bit data word. Reads return the stored word most significant bit first. Writes are gated by an enable latch. Each write starts a self-timed programming interval of a parameterised number of system clocks. While that interval runs, the block reports busy on the ready pin and, when selected, on the data output. The abort input cancels writes only.

The serial pins carry no valid/ready handshake, because the host owns the shift clock and there is no back-pressure. All pins are plain levels.

Top module: `spi_word_eeprom`

## Requirements
- R1: After system reset, ready is high, the data output is disabled, the enable latch is clear, and every word reads as 0.
- R2: While selected and idle, bits are shifted through a 4-bit window, and a frame starts only when the window holds 1010. Bits before that are ignored.
- R3: Command nibble 1000 (byte 0xA8) is a read. The output enable rises after the falling shift edge that ends the address, with bit 15 first. Each later falling edge presents the next bit. The output is disabled again after the falling edge that follows bit 0.
- R4: Command nibble 0100 (0xA4) writes the 16 data bits to the addressed word. Ready goes low after the rising edge of the 32nd bit and rises at most PROG_CYCLES clocks later.
- R5: A write or write-all issued while the enable latch is clear leaves ready high and all words unchanged.
- R6: Nibble 0011 (0xA3) sets the enable latch, and nibble 0000 (0xA0) clears it.
- R7: Nibble 0001 (0xA1) stores the data word into every location when programming completes.
- R8: Abort asserted while a write frame is being shifted in cancels that write.
- R9: Abort asserted during programming raises ready within a few clocks and leaves the target word unchanged.
- R10: Abort has no effect on read, enable or disable frames.
- R11: During programming, a low select drives the output as 0 and a high select disables it. After completion, a low select drives 1 until a 1 is shifted in on the data input.
- R12: An unrecognised command nibble makes the block ignore all further bits until select goes high.
- R13: Raising select in the middle of a frame abandons the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cs_n_i | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial shift clock; data in is sampled on its rise |
| sdi_i | input | 1 | Serial data in |
| abort_i | input | 1 | Active-high write abort |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Output enable for sdo_o (0 = high impedance) |
| rdy_o | output | 1 | High when no programming cycle is running |

## Verification
A corrupted frame counter or a wrong decoded command shows up within the same frame. A read returns a shifted or wrong word, or the output enable appears on the wrong falling edge. A write may start programming that should have been refused, and ready then drops right after the 32nd bit. A stuck enable latch or a broken abort path shows up after the programming interval. Ready then stays low too long, or the word read back holds data that should never have landed. A wrong status flag shows up the next time select goes low, as a wrong level or a wrong enable on the data output.

// File: rtl/swe_pkg.sv
package swe_pkg;
  localparam int          OP_W      = 4;
  localparam logic [3:0]  START_PAT = 4'b1010;
  localparam logic [3:0]  OPC_READ  = 4'b1000;
  localparam logic [3:0]  OPC_WRITE = 4'b0100;
  localparam logic [3:0]  OPC_WREN  = 4'b0011;
  localparam logic [3:0]  OPC_WRDIS = 4'b0000;
  localparam logic [3:0]  OPC_WRALL = 4'b0001;

  typedef enum logic [2:0] {
    F_HUNT,
    F_CMD,
    F_DATA,
    F_RDWAIT,
    F_RDOUT,
    F_DONE
  } fstate_e;
endpackage

// File: rtl/swe_sync.sv
module swe_sync #(
  parameter int           W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/swe_array.sv
module swe_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          all,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[g] <= '0;
      else if (we && (all || waddr == AW'(g))) mem[g] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  AST_WORD0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem[0]));  // R5
endmodule

// File: rtl/swe_ptimer.sv
module swe_ptimer #(
  parameter int PROG_CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic commit,
  output logic finish
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      left   <= '0;
      commit <= 1'b0;
      finish <= 1'b0;
    end else begin
      commit <= 1'b0;
      finish <= 1'b0;
      if (busy) begin
        if (abort) begin
          busy   <= 1'b0;
          finish <= 1'b1;
        end else if (left == CW'(1)) begin
          busy   <= 1'b0;
          commit <= 1'b1;
          finish <= 1'b1;
        end else begin
          left <= left - 1'b1;
        end
      end else if (start && !abort) begin
        busy <= 1'b1;
        left <= CW'(PROG_CYCLES);
      end
    end
  end

  AST_ABORT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && abort |=> !busy && !commit);  // R9
  AST_COMMIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(busy) && !busy);  // R4
endmodule

// File: rtl/swe_frame.sv
module swe_frame
  import swe_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sk_rise,
  input  logic          sk_fall,
  input  logic          di,
  input  logic          abort,
  input  logic          busy,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] addr_q,
  output logic          rd_oe,
  output logic          rd_bit,
  output logic          wel,
  output logic          prog_start,
  output logic          prog_all,
  output logic [DW-1:0] prog_data
);
  localparam int CMD_W = OP_W + AW;
  localparam int CNT_W = $clog2((DW > CMD_W) ? DW : CMD_W);

  fstate_e        st;
  logic [2:0]     win;
  logic [CMD_W-2:0] cmd_sr;
  logic [DW-2:0]  data_sr;
  logic [DW-1:0]  rd_sr;
  logic [CNT_W-1:0] cnt;
  logic           cancel;
  logic [CMD_W-1:0] cmd_nx;
  logic [DW-1:0]  data_nx;
  logic [OP_W-1:0] opc;

  always_comb begin
    cmd_nx  = {cmd_sr, di};
    data_nx = {data_sr, di};
    opc     = cmd_nx[CMD_W-1 -: OP_W];
  end

  assign rd_bit = rd_sr[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= F_HUNT;
      win        <= '0;
      cmd_sr     <= '0;
      data_sr    <= '0;
      rd_sr      <= '0;
      cnt        <= '0;
      cancel     <= 1'b0;
      addr_q     <= '0;
      rd_oe      <= 1'b0;
      wel        <= 1'b0;
      prog_start <= 1'b0;
      prog_all   <= 1'b0;
      prog_data  <= '0;
    end else begin
      prog_start <= 1'b0;
      if (cs_n) begin
        st     <= F_HUNT;
        win    <= '0;
        cancel <= 1'b0;
        rd_oe  <= 1'b0;
      end else begin
        if (abort && (st == F_CMD || st == F_DATA)) cancel <= 1'b1;
        unique case (st)
          F_HUNT: begin
            if (sk_rise && !busy) begin
              win <= {win[1:0], di};
              if ({win, di} == START_PAT) begin
                st     <= F_CMD;
                cnt    <= '0;
                cancel <= abort;
              end
            end
          end
          F_CMD: begin
            if (sk_rise) begin
              cmd_sr <= cmd_nx[CMD_W-2:0];
              cnt    <= cnt + 1'b1;
              if (cnt == CNT_W'(CMD_W - 1)) begin
                addr_q <= cmd_nx[AW-1:0];
                cnt    <= '0;
                case (opc)
                  OPC_READ:  st <= F_RDWAIT;
                  OPC_WRITE: begin st <= F_DATA; prog_all <= 1'b0; end
                  OPC_WRALL: begin st <= F_DATA; prog_all <= 1'b1; end
                  OPC_WREN:  begin st <= F_DONE; wel <= 1'b1; end
                  OPC_WRDIS: begin st <= F_DONE; wel <= 1'b0; end
                  default:   st <= F_DONE;
                endcase
              end
            end
          end
          F_DATA: begin
            if (sk_rise) begin
              data_sr <= data_nx[DW-2:0];
              cnt     <= cnt + 1'b1;
              if (cnt == CNT_W'(DW - 1)) begin
                st        <= F_DONE;
                prog_data <= data_nx;
                if (wel && !cancel && !abort) prog_start <= 1'b1;
              end
            end
          end
          F_RDWAIT: begin
            if (sk_fall) begin
              rd_sr <= rd_word;
              rd_oe <= 1'b1;
              cnt   <= '0;
              st    <= F_RDOUT;
            end
          end
          F_RDOUT: begin
            if (sk_fall) begin
              if (cnt == CNT_W'(DW - 1)) begin
                rd_oe <= 1'b0;
                st    <= F_DONE;
              end else begin
                rd_sr <= rd_sr << 1;
                cnt   <= cnt + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_READ_IDLE_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> !busy);  // R3
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !busy);  // R4
endmodule

// File: rtl/spi_word_eeprom.sv
module spi_word_eeprom #(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic abort_i,
  output logic sdo_o,
  output logic sdo_oe_o,
  output logic rdy_o
);
  logic cs_s, sck_s, sdi_s, abort_s, sck_q;
  logic sk_rise, sk_fall;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rd_word, prog_data;
  logic rd_oe, rd_bit, wel, prog_start, prog_all;
  logic busy, commit, finish, poll_done;

  swe_sync #(.W(4), .RST_VAL(4'b0001)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({abort_i, sdi_i, sck_i, cs_n_i}),
    .q    ({abort_s, sdi_s, sck_s, cs_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end

  assign sk_rise = sck_s & ~sck_q;
  assign sk_fall = ~sck_s & sck_q;

  swe_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_s),
    .sk_rise   (sk_rise),
    .sk_fall   (sk_fall),
    .di        (sdi_s),
    .abort     (abort_s),
    .busy      (busy),
    .rd_word   (rd_word),
    .addr_q    (addr_q),
    .rd_oe     (rd_oe),
    .rd_bit    (rd_bit),
    .wel       (wel),
    .prog_start(prog_start),
    .prog_all  (prog_all),
    .prog_data (prog_data)
  );

  swe_ptimer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (prog_start),
    .abort (abort_s),
    .busy  (busy),
    .commit(commit),
    .finish(finish)
  );

  swe_array #(.AW(AW), .DW(DW)) u_array (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (commit),
    .all  (prog_all),
    .waddr(addr_q),
    .wdata(prog_data),
    .raddr(addr_q),
    .rdata(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 poll_done <= 1'b0;
    else if (finish)                            poll_done <= 1'b1;
    else if (prog_start)                        poll_done <= 1'b0;
    else if (!cs_s && sk_rise && sdi_s && !busy) poll_done <= 1'b0;
  end

  always_comb begin
    if (rd_oe && !cs_s) begin
      sdo_oe_o = 1'b1;
      sdo_o    = rd_bit;
    end else if (!cs_s && busy) begin
      sdo_oe_o = 1'b1;
      sdo_o    = 1'b0;
    end else if (!cs_s && poll_done) begin
      sdo_oe_o = 1'b1;
      sdo_o    = 1'b1;
    end else begin
      sdo_oe_o = 1'b0;
      sdo_o    = 1'b0;
    end
  end

  assign rdy_o = ~busy;

  AST_PROG_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));  // R5
  AST_NO_READ_OUT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_oe);  // R11
endmodule

// File: tb/spi_word_eeprom_tb.sv
module spi_word_eeprom_tb;
  localparam int PROG = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, abort = 1'b0;
  logic sdo, sdo_oe, rdy;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  spi_word_eeprom #(.PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi),
    .abort_i(abort), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .rdy_o(rdy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo(); cs_n = 1'b0; ticks(6); endtask
  task automatic cs_hi(); cs_n = 1'b1; ticks(8); endtask

  task automatic send(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      ticks(6);
      sck = 1'b1;
      ticks(6);
      sck = 1'b0;
    end
  endtask

  task automatic read_word(input logic [7:0] addr, input logic [15:0] pre, input int npre,
                           output logic [15:0] got, output logic oe_ok);
    oe_ok = 1'b1;
    cs_lo();
    if (npre > 0) send(pre, npre);
    send(16'hA8, 8);
    send({8'h0, addr}, 8);
    for (int i = 15; i >= 0; i--) begin
      ticks(6);
      got[i] = sdo;
      if (sdo_oe !== 1'b1) oe_ok = 1'b0;
      sck = 1'b1;
      ticks(6);
      sck = 1'b0;
    end
    ticks(6);
    if (sdo_oe !== 1'b0) oe_ok = 1'b0;
    cs_hi();
  endtask

  task automatic write_frame(input logic [7:0] op, input logic [7:0] addr,
                             input logic [15:0] data, input logic exp_busy, input string req);
    cs_lo();
    send({8'h0, op}, 8);
    send({8'h0, addr}, 8);
    send(data >> 1, 15);
    sdi = data[0];
    ticks(6);
    chk(req, rdy, 1);
    sck = 1'b1;
    ticks(8);
    chk(req, rdy, !exp_busy);
    sck = 1'b0;
    ticks(6);
    cs_hi();
  endtask

  task automatic cmd_frame(input logic [7:0] op);
    cs_lo();
    send({8'h0, op}, 8);
    send(16'h0, 8);
    cs_hi();
  endtask

  task automatic wait_ready(output int cycles);
    cycles = 0;
    while (rdy !== 1'b1 && cycles < PROG + 100) begin
      ticks(1);
      cycles++;
    end
  endtask

  task automatic expect_word(input logic [7:0] a, input logic [15:0] exp, input string req);
    logic [15:0] got;
    logic ok;
    read_word(a, 16'h0, 0, got, ok);
    chk(req, got, exp);
    chk(req, ok, 1);
  endtask

  task automatic t_reset();
    chk("R1 rdy", rdy, 1);
    chk("R1 oe", sdo_oe, 0);
    expect_word(8'h12, 16'h0000, "R1 word");
  endtask

  task automatic t_no_enable();
    write_frame(8'hA4, 8'h12, 16'hBEEF, 1'b0, "R5 write gated");
    write_frame(8'hA1, 8'h00, 16'h7777, 1'b0, "R5 write-all gated");
    expect_word(8'h12, 16'h0000, "R5 unchanged");
  endtask

  task automatic t_write_read();
    int c;
    cmd_frame(8'hA3);
    write_frame(8'hA4, 8'h12, 16'hBEEF, 1'b1, "R4 busy after 32nd");
    wait_ready(c);
    chk("R4 ready returns", rdy, 1);
    chk("R4 interval", (c >= PROG - 100 && c <= PROG), 1);
    write_frame(8'hA4, 8'h34, 16'h1234, 1'b1, "R4 second");
    wait_ready(c);
    expect_word(8'h12, 16'hBEEF, "R3 read a");
    expect_word(8'h34, 16'h1234, "R3 read b");
    chk("R3 hi-z deselected", sdo_oe, 0);
  endtask

  task automatic t_hunt();
    logic [15:0] got;
    logic ok;
    read_word(8'h34, 16'b11100, 5, got, ok);
    chk("R2 junk prefix", got, 16'h1234);
    chk("R2 oe", ok, 1);
  endtask

  task automatic t_poll();
    int c;
    write_frame(8'hA4, 8'h60, 16'h6060, 1'b1, "R11 start");
    cs_lo();
    chk("R11 busy oe", sdo_oe, 1);
    chk("R11 busy level", sdo, 0);
    cs_hi();
    chk("R11 deselect hi-z", sdo_oe, 0);
    wait_ready(c);
    cs_lo();
    chk("R11 done oe", sdo_oe, 1);
    chk("R11 done level", sdo, 1);
    send(16'h0, 1);
    chk("R11 zero keeps", {sdo_oe, sdo}, 2'b11);
    send(16'h1, 1);
    ticks(4);
    chk("R11 one clears", sdo_oe, 0);
    cs_hi();
    expect_word(8'h60, 16'h6060, "R11 stored");
  endtask

  task automatic t_abort_shift();
    cs_lo();
    send(16'hA4, 8);
    send(16'h70, 8);
    send(16'hCA, 8);
    abort = 1'b1;
    ticks(10);
    abort = 1'b0;
    send(16'hFE, 8);
    ticks(8);
    chk("R8 no busy", rdy, 1);
    cs_hi();
    expect_word(8'h70, 16'h0000, "R8 unchanged");
  endtask

  task automatic t_abort_prog();
    int c;
    write_frame(8'hA4, 8'h40, 16'hAAAA, 1'b1, "R9 start");
    ticks(20);
    abort = 1'b1;
    ticks(5);
    chk("R9 ready at once", rdy, 1);
    abort = 1'b0;
    wait_ready(c);
    ticks(PROG);
    expect_word(8'h40, 16'h0000, "R9 unchanged");
  endtask

  task automatic t_abort_other();
    int c;
    logic [15:0] got;
    logic ok;
    abort = 1'b1;
    cmd_frame(8'hA0);
    abort = 1'b0;
    write_frame(8'hA4, 8'h50, 16'h1111, 1'b0, "R10 disable under abort");
    abort = 1'b1;
    cmd_frame(8'hA3);
    abort = 1'b0;
    write_frame(8'hA4, 8'h50, 16'h2222, 1'b1, "R10 enable under abort");
    wait_ready(c);
    abort = 1'b1;
    read_word(8'h50, 16'h0, 0, got, ok);
    abort = 1'b0;
    chk("R10 read under abort", got, 16'h2222);
    chk("R10 read oe", ok, 1);
  endtask

  task automatic t_bad_op();
    int bad = 0;
    cs_lo();
    send(16'hAF, 8);
    send(16'hA8, 8);
    send(16'h12, 8);
    for (int i = 0; i < 16; i++) begin
      ticks(6);
      if (sdo_oe !== 1'b0) bad++;
      sck = 1'b1;
      ticks(6);
      sck = 1'b0;
    end
    chk("R12 ignored", bad, 0);
    cs_hi();
  endtask

  task automatic t_cs_break();
    cs_lo();
    send(16'b101010, 6);
    cs_hi();
    expect_word(8'h12, 16'hBEEF, "R13 fresh frame");
  endtask

  task automatic t_disable();
    cmd_frame(8'hA0);
    write_frame(8'hA4, 8'h12, 16'h0000, 1'b0, "R6 disabled");
    expect_word(8'h12, 16'hBEEF, "R6 unchanged");
    cmd_frame(8'hA3);
  endtask

  task automatic t_write_all();
    int c;
    write_frame(8'hA1, 8'h99, 16'h5A5A, 1'b1, "R7 start");
    wait_ready(c);
    expect_word(8'h00, 16'h5A5A, "R7 low");
    expect_word(8'h34, 16'h5A5A, "R7 mid");
    expect_word(8'hFF, 16'h5A5A, "R7 top");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    ticks(5);
    rst_n = 1'b1;
    ticks(5);
    t_reset();
    t_no_enable();
    t_write_read();
    t_hunt();
    t_poll();
    t_abort_shift();
    t_abort_prog();
    t_abort_other();
    t_bad_op();
    t_cs_break();
    t_disable();
    t_write_all();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule